// File: doc/BRIEF.md
# Constant-Fraction Time-Mark Gate

This block turns two digitized comparator streams into a precise timing strobe. A baseline comparator (`lvl_i`) reports that the detector pulse has passed a low acceptance level. A zero-crossing comparator (`zc_i`) rises at the constant-fraction crossing point, which carries the exact time of the event. Both signals are synchronous single-bit samples on a fast clock. The gate lets the crossing edge through as a one-cycle mark only when the baseline condition holds. It also stretches each mark into a fixed-width fast output pulse.

A mode input picks between two policies. In constant-fraction mode (`mode_i` = 0), a crossing that arrives while the baseline comparator is still low is not lost. It is held pending and released when the baseline comparator asserts, which gives the mixed leading-edge behaviour of a plain constant-fraction discriminator. In slow-risetime-reject mode (`mode_i` = 1), the baseline comparator must already have been high in the cycle before the crossing. A crossing that fails this test is dropped and reported on a one-cycle reject strobe, so that the loss of efficiency can be counted. An external deadtime input (`block_i`) suppresses every candidate while it is high.

Top module: `cfd_mark_gate`

## Requirements
- R1: While reset is applied, and after it is released with idle inputs, `mark_o`, `pulse_o` and `rej_o` are all 0.
- R2: With `mode_i`=0, a 0-to-1 change of `zc_i` in a cycle where `lvl_i` is 1 gives `mark_o`=1 for exactly one cycle, in the cycle that follows. This holds whether `lvl_i` rose earlier or in that same cycle.
- R3: With `mode_i`=0, a rise of `zc_i` while `lvl_i` is 0 is held pending. `mark_o` pulses one cycle after the first cycle in which `lvl_i` is 1 while `zc_i` is still 1. If `zc_i` returns to 0 first, no mark is made.
- R4: With `mode_i`=1, a rise of `zc_i` gives a mark only if `lvl_i` was 1 in the cycle before the rise. Otherwise, including when `lvl_i` rises in the same cycle, `rej_o` pulses for one cycle and no mark is made.
- R5: Each rising edge of `zc_i` yields at most one mark or reject. Holding `zc_i` at 1 produces nothing further.
- R6: Arming is not sticky. A baseline pulse that ended before the cycle preceding the crossing does not arm slow-risetime-reject mode, so that crossing is rejected.
- R7: While `block_i` is 1, a crossing produces neither a mark nor a reject, and any constant-fraction pending crossing is discarded.
- R8: `pulse_o` goes to 1 in the same cycle as `mark_o` and stays at 1 for exactly `PULSE_LEN` cycles.
- R9: `mark_o` and `rej_o` are never 1 together, and `rej_o` occurs only in slow-risetime-reject mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 0 = constant-fraction, 1 = slow-risetime-reject |
| lvl_i | input | 1 | Baseline level comparator sample |
| zc_i | input | 1 | Zero-crossing comparator sample |
| block_i | input | 1 | Deadtime blocking from outside |
| mark_o | output | 1 | One-cycle time-mark strobe |
| pulse_o | output | 1 | Fixed-width fast output pulse |
| rej_o | output | 1 | One-cycle reject strobe for slow-risetime discards |

## Verification
On every cycle, the assertions enforce the following: marks and rejects stay exclusive, a mark never comes twice in a row, rejects appear only in slow-risetime-reject mode, nothing leaves the gate after a blocked cycle, an accepted slow-risetime mark had its baseline high one cycle before the crossing, and the fast pulse starts with its mark. Some behaviours depend on a particular ordering of the two comparators, and only the directed scenarios can show them. These are the late-baseline release of a pending constant-fraction crossing, the way a pending crossing is cancelled by a falling zero-crossing or by blocking, the exact pulse width, and the rejection of a crossing that is simultaneous with the baseline or follows a baseline pulse that has already ended.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  typedef enum logic {
    MODE_CF = 1'b0,
    MODE_SR = 1'b1
  } cfd_mode_e;

  typedef struct packed {
    logic accept;
    logic reject;
  } cfd_verdict_t;
endpackage

// File: rtl/cfd_edge.sv
module cfd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic prev_o,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign prev_o = prev_q;
  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/cfd_gate.sv
module cfd_gate
  import cfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic lvl_i,
  input  logic lvl_prev_i,
  input  logic zc_i,
  input  logic zc_rise_i,
  input  logic block_i,
  output logic accept_o,
  output logic mark_o,
  output logic rej_o
);
  cfd_mode_e    mode;
  cfd_verdict_t vd;
  logic pend_q, pend_d;
  logic mark_q, rej_q;

  assign mode = cfd_mode_e'(mode_i);

  always_comb begin
    vd     = '0;
    pend_d = 1'b0;
    if (!block_i) begin
      if (mode == MODE_CF) begin
        vd.accept = (zc_rise_i & lvl_i) | (pend_q & zc_i & lvl_i);
        pend_d    = (zc_rise_i | pend_q) & zc_i & ~lvl_i;
      end else begin
        vd.accept = zc_rise_i & lvl_prev_i;
        vd.reject = zc_rise_i & ~lvl_prev_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      mark_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mark_q <= vd.accept;
      rej_q  <= vd.reject;
    end
  end

  assign accept_o = vd.accept;
  assign mark_o   = mark_q;
  assign rej_o    = rej_q;

  // R9
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_q && rej_q));
  // R9
  rej_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> $past(mode_i));
  // R7
  block_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(block_i) |-> (!mark_q && !rej_q));
  // R4
  sr_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_q && $past(mode_i)) |-> $past(lvl_prev_i));
  // R5
  single_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |=> !mark_q);
endmodule

// File: rtl/cfd_stretch.sv
module cfd_stretch #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (cnt_q != '0);
    cnt_d  = load_i ? LOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pulse_o = (cnt_q != '0);

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
endmodule

// File: rtl/cfd_mark_gate.sv
module cfd_mark_gate #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic lvl_i,
  input  logic zc_i,
  input  logic block_i,
  output logic mark_o,
  output logic pulse_o,
  output logic rej_o
);
  logic [1:0] rsync_q;
  logic       srst_n;
  logic       lvl_prev, lvl_rise_unused;
  logic       zc_prev_unused, zc_rise;
  logic       accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  cfd_edge u_lvl (
    .clk(clk), .rst_n(srst_n), .sig_i(lvl_i),
    .prev_o(lvl_prev), .rise_o(lvl_rise_unused)
  );

  cfd_edge u_zc (
    .clk(clk), .rst_n(srst_n), .sig_i(zc_i),
    .prev_o(zc_prev_unused), .rise_o(zc_rise)
  );

  cfd_gate u_gate (
    .clk(clk), .rst_n(srst_n), .mode_i(mode_i),
    .lvl_i(lvl_i), .lvl_prev_i(lvl_prev),
    .zc_i(zc_i), .zc_rise_i(zc_rise), .block_i(block_i),
    .accept_o(accept), .mark_o(mark_o), .rej_o(rej_o)
  );

  cfd_stretch #(.PULSE_LEN(PULSE_LEN)) u_str (
    .clk(clk), .rst_n(srst_n), .load_i(accept), .pulse_o(pulse_o)
  );

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!srst_n)
    mark_o |-> pulse_o);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !srst_n |-> (!mark_o && !pulse_o && !rej_o));
endmodule

// File: tb/sim_cfd_mark_gate.sv
`timescale 1ns/100ps
module sim_cfd_mark_gate;
  localparam int PLEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, lvl = 1'b0, zc = 1'b0, blk = 1'b0;
  logic mark, pulse, rej;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfd_mark_gate #(.PULSE_LEN(PLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .lvl_i(lvl), .zc_i(zc),
    .block_i(blk), .mark_o(mark), .pulse_o(pulse), .rej_o(rej)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, sample just after the next rising edge
  task automatic tick(input logic z, input logic l, input logic b);
    @(negedge clk);
    zc = z; lvl = l; blk = b;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 mark", mark, 1'b0);
    chk("R1 pulse", pulse, 1'b0);
    chk("R1 rej", rej, 1'b0);
  endtask

  task automatic t_cf_basic;
    int w;
    mode = 1'b0; idle(2);
    tick(0, 1, 0); chk("R2 early", mark, 1'b0);
    tick(1, 1, 0); chk("R2 mark", mark, 1'b1);
    chk("R8 start", pulse, 1'b1);
    w = 1;
    for (int i = 0; i < 10; i++) begin
      tick(1, 1, 0);
      chk("R5 held", mark, 1'b0);
      if (pulse) w++;
    end
    n_chk++;
    if (w != PLEN) begin
      n_bad++;
      $display("FAIL R8 width: got %0d expected %0d", w, PLEN);
    end
    idle(3);
    tick(1, 1, 0); chk("R2 same-cycle", mark, 1'b1);
    chk("R9 no rej cf", rej, 1'b0);
    idle(6);
  endtask

  task automatic t_cf_late;
    mode = 1'b0; idle(2);
    tick(1, 0, 0); chk("R3 pend", mark, 1'b0);
    tick(1, 0, 0); chk("R3 pend2", mark, 1'b0);
    tick(1, 1, 0); chk("R3 late mark", mark, 1'b1);
    tick(1, 1, 0); chk("R3 once", mark, 1'b0);
    idle(6);
    tick(1, 0, 0); tick(0, 0, 0); tick(0, 1, 0);
    chk("R3 cancel", mark, 1'b0);
    tick(0, 1, 0); chk("R3 cancel2", mark, 1'b0);
    idle(6);
  endtask

  task automatic t_sr;
    mode = 1'b1; idle(2);
    tick(0, 1, 0); tick(1, 1, 0);
    chk("R4 armed mark", mark, 1'b1); chk("R4 armed rej", rej, 1'b0);
    idle(6);
    tick(1, 1, 0);
    chk("R4 simul mark", mark, 1'b0); chk("R4 simul rej", rej, 1'b1);
    tick(1, 1, 0); chk("R5 no second rej", rej, 1'b0);
    idle(2);
    tick(1, 0, 0); chk("R4 late rej", rej, 1'b1);
    tick(1, 1, 0); chk("R4 late mark", mark, 1'b0);
    chk("R4 late pulse", pulse, 1'b0);
    idle(2);
    tick(0, 1, 0); tick(0, 0, 0); tick(1, 0, 0);
    chk("R6 stale rej", rej, 1'b1); chk("R6 stale mark", mark, 1'b0);
    idle(6);
  endtask

  task automatic t_block;
    mode = 1'b1; idle(2);
    tick(0, 1, 0); tick(1, 1, 1);
    chk("R7 sr mark", mark, 1'b0); chk("R7 sr rej", rej, 1'b0);
    chk("R7 sr pulse", pulse, 1'b0);
    tick(0, 1, 0); tick(1, 1, 0);
    chk("R7 after release", mark, 1'b1);
    idle(6);
    mode = 1'b0;
    tick(1, 0, 0); tick(1, 1, 1); chk("R7 cf blocked", mark, 1'b0);
    tick(1, 1, 0); chk("R7 pend dropped", mark, 1'b0);
    chk("R7 pend pulse", pulse, 1'b0);
    idle(6);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    t_reset();
    t_cf_basic();
    t_cf_late();
    t_sr();
    t_block();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule